// File: doc/BRIEF.md
# Per-Processor Masked Device Interrupt Router

This block gathers 64 device interrupt sources and routes them to as many as four processors. It keeps one global vector of raw requests. Devices set and clear bits in it with single-cycle strobes. Each processor has its own 64-bit enable mask. A processor's pending vector is always the AND of its mask with the raw vector. The processor sees a level interrupt while that pending vector is nonzero, along with the index of the lowest pending source.

Software reaches the block over a simple 64-bit register bus. The register number is the byte address shifted right by six. The mask registers can be written. The pending and raw vectors can only be read. Any access that is illegal returns an error pulse and changes nothing.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset, every mask, pending vector and raw bit is zero, `cpu_irq` is all low and every `cpu_low_idx` field is 0.
- R2: An assert strobe on source line n sets raw bit n. At the clock edge that samples the strobe, every processor whose mask has bit n set gets pending bit n, so `cpu_irq` rises one cycle after the strobe.
- R3: A deassert strobe on line n clears raw bit n and withdraws pending bit n from every processor at the same edge.
- R4: A deassert strobe on a line whose raw bit is already clear is spurious. It changes no raw, pending or output state.
- R5: A mask write replaces that processor's mask. Its pending vector becomes new mask AND raw on the same edge, so bits that become enabled while raw is set raise the interrupt, and bits that are disabled withdraw it.
- R6: The register number is `csr_addr[11:6]`. Registers 0 to 3 are the masks of processors 0 to 3 (read and write). Registers 4 to 7 are their pending vectors (read only). Register 8 is the raw vector (read only). Each access returns `csr_ack`, `csr_rdata` and `csr_err` one cycle after `csr_valid`.
- R7: Any of the following sets `csr_err` for one cycle, returns zero read data and changes no state: a `csr_size` other than 3 (sizes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes), a nonzero `csr_addr[5:0]`, a write to registers 4 to 8, or any access to a register above 8.
- R8: `cpu_irq[c]` is high exactly when pending vector c is nonzero. `cpu_low_idx[6c+5:6c]` gives the lowest set pending bit, and reads 0 when nothing is pending.
- R9: If one line receives an assert and a deassert strobe in the same cycle, the assert wins and the raw bit ends up set.
- R10: The processors are independent. A mask write to one processor leaves every other processor's mask, pending vector and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_assert | input | 64 | Per-line request assert strobes |
| src_deassert | input | 64 | Per-line request deassert strobes |
| csr_valid | input | 1 | Register access valid for one cycle |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte address in the register window |
| csr_size | input | 2 | Access size code (3 = 8 bytes) |
| csr_wdata | input | 64 | Write data |
| csr_ack | output | 1 | Access response, one cycle after valid |
| csr_err | output | 1 | Error response for an illegal access |
| csr_rdata | output | 64 | Read data, valid with ack |
| cpu_irq | output | 4 | Per-processor device interrupt level |
| cpu_low_idx | output | 24 | Per-processor lowest pending source index, 6 bits each |

## Verification
The assertions assume that `csr_valid` lasts one cycle per access. They also assume that strobes are single-cycle vectors sampled at the clock edge, so that the raw and mask updates of one edge can be compared with the state one cycle later. The stimulus always drives inputs on the falling edge. It holds each strobe or access for exactly one cycle and leaves at least one idle cycle between operations, which keeps every response in a known cycle. Same-cycle collisions occur only where they are tested on purpose (R9).

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int CPU_MAX   = 4;
    localparam int CPU_W     = 2;
    localparam int DATA_W    = 64;
    localparam int REG_SHIFT = 6;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_MASK = 2'd1,
        RS_PEND = 2'd2,
        RS_RAW  = 2'd3
    } rsel_kind_e;

    typedef struct packed {
        rsel_kind_e         kind;
        logic [CPU_W-1:0]   cpu;
    } rsel_t;

endpackage

// File: rtl/irq_raw_latch.sv
module irq_raw_latch #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_assert,
    input  logic [NUM_SRC-1:0] src_deassert,
    output logic [NUM_SRC-1:0] raw_q,
    output logic [NUM_SRC-1:0] raw_next
);

    // assert has priority over deassert on the same line (R9)
    always_comb raw_next = (raw_q & ~src_deassert) | src_assert;

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= raw_next;
    end

    // R2 / R9: every asserted line is set after the edge
    a_r2_assert_sets: assert property (@(posedge clk) disable iff (rst)
        (src_assert != '0) |=> ((raw_q & $past(src_assert)) == $past(src_assert)));

    // R3: deasserted lines without a colliding assert are cleared
    a_r3_deassert_clears: assert property (@(posedge clk) disable iff (rst)
        ((src_deassert & ~src_assert) != '0) |=>
        ((raw_q & $past(src_deassert & ~src_assert)) == '0));

    // R4: spurious deassert leaves a clear bit clear
    a_r4_spurious_quiet: assert property (@(posedge clk) disable iff (rst)
        ((src_deassert & ~raw_q & ~src_assert) != '0) |=>
        ((raw_q & $past(src_deassert & ~raw_q & ~src_assert)) == '0));

endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12
) (
    input  logic              csr_valid,
    input  logic              csr_write,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [1:0]        csr_size,
    output logic [NUM_CPU-1:0] mask_we,
    output rsel_t             rsel,
    output logic              err
);

    localparam int RIDX_W = ADDR_W - REG_SHIFT;
    localparam logic [RIDX_W-1:0] PEND_BASE = RIDX_W'(NUM_CPU);
    localparam logic [RIDX_W-1:0] RAW_IDX   = RIDX_W'(2 * NUM_CPU);

    logic [RIDX_W-1:0]    ridx;
    logic [REG_SHIFT-1:0] roff;
    logic [RIDX_W-1:0]    psub;

    assign ridx = csr_addr[ADDR_W-1:REG_SHIFT];
    assign roff = csr_addr[REG_SHIFT-1:0];
    assign psub = ridx - PEND_BASE;

    always_comb begin
        mask_we   = '0;
        rsel.kind = RS_NONE;
        rsel.cpu  = '0;
        err       = 1'b0;
        if (csr_valid) begin
            if (csr_size != 2'(ACC_DWORD) || roff != '0) begin
                err = 1'b1;
            end else if (ridx < PEND_BASE) begin
                rsel.cpu = ridx[CPU_W-1:0];
                if (csr_write) mask_we   = NUM_CPU'(1) << ridx;
                else           rsel.kind = RS_MASK;
            end else if (ridx < RAW_IDX) begin
                rsel.cpu = psub[CPU_W-1:0];
                if (csr_write) err       = 1'b1;
                else           rsel.kind = RS_PEND;
            end else if (ridx == RAW_IDX) begin
                if (csr_write) err       = 1'b1;
                else           rsel.kind = RS_RAW;
            end else begin
                err = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] raw_next,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               irq,
    output logic [IDX_W-1:0]   low_idx
);

    logic [NUM_SRC-1:0] mask_d;

    function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    assign mask_d = mask_we ? wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            mask_q <= mask_d;
            pend_q <= mask_d & raw_next;
        end
    end

    assign irq     = |pend_q;
    assign low_idx = lowest_set(pend_q);

    // R8: the reported index points at a pending bit
    a_r8_idx_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend_q[low_idx]);

    // R8: no pending source reports index zero
    a_r8_idle_idx: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (low_idx == '0));

    // R10: the mask only moves on its own write enable
    a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));

    // R8: lowest index has no pending bit below it
    a_r8_lowest: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((pend_q & ((NUM_SRC'(1) << low_idx) - NUM_SRC'(1))) == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       src_assert,
    input  logic [NUM_SRC-1:0]       src_deassert,
    input  logic                     csr_valid,
    input  logic                     csr_write,
    input  logic [ADDR_W-1:0]        csr_addr,
    input  logic [1:0]               csr_size,
    input  logic [NUM_SRC-1:0]       csr_wdata,
    output logic                     csr_ack,
    output logic                     csr_err,
    output logic [NUM_SRC-1:0]       csr_rdata,
    output logic [NUM_CPU-1:0]       cpu_irq,
    output logic [NUM_CPU*IDX_W-1:0] cpu_low_idx
);

    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] raw_next;
    logic [NUM_SRC-1:0] mask_q [NUM_CPU];
    logic [NUM_SRC-1:0] pend_q [NUM_CPU];
    logic [NUM_CPU-1:0] mask_we;
    rsel_t              rsel;
    logic               dec_err;
    logic [NUM_SRC-1:0] rd_next;

    irq_raw_latch #(.NUM_SRC(NUM_SRC)) u_raw (
        .clk          (clk),
        .rst          (rst),
        .src_assert   (src_assert),
        .src_deassert (src_deassert),
        .raw_q        (raw_q),
        .raw_next     (raw_next)
    );

    irq_csr_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
        .csr_valid (csr_valid),
        .csr_write (csr_write),
        .csr_addr  (csr_addr),
        .csr_size  (csr_size),
        .mask_we   (mask_we),
        .rsel      (rsel),
        .err       (dec_err)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [IDX_W-1:0] idx_c;
        irq_cpu_slice #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_slice (
            .clk      (clk),
            .rst      (rst),
            .mask_we  (mask_we[c]),
            .wdata    (csr_wdata),
            .raw_next (raw_next),
            .mask_q   (mask_q[c]),
            .pend_q   (pend_q[c]),
            .irq      (cpu_irq[c]),
            .low_idx  (idx_c)
        );
        assign cpu_low_idx[c*IDX_W +: IDX_W] = idx_c;

        // R5: pending tracks mask and raw from the other two blocks
        a_r5_pend_tracks: assert property (@(posedge clk) disable iff (rst)
            pend_q[c] == (mask_q[c] & raw_q));
    end

    always_comb begin
        unique case (rsel.kind)
            RS_MASK: rd_next = mask_q[rsel.cpu];
            RS_PEND: rd_next = pend_q[rsel.cpu];
            RS_RAW:  rd_next = raw_q;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_ack   <= 1'b0;
            csr_err   <= 1'b0;
            csr_rdata <= '0;
        end else begin
            csr_ack   <= csr_valid;
            csr_err   <= dec_err;
            csr_rdata <= rd_next;
        end
    end

    // R7: wrong access size is answered with an error
    a_r7_bad_size: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && csr_size != 2'(ACC_DWORD)) |=> (csr_err && csr_ack));

    // R7: a failing access touches no mask
    a_r7_err_no_write: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (mask_we == '0));

    // R6: every response follows a request by one cycle
    a_r6_ack_timing: assert property (@(posedge clk) disable iff (rst)
        csr_ack |-> $past(csr_valid));

    // R7: error data is zero
    a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
        csr_err |-> (csr_rdata == '0));

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam int NS = 64;
    localparam int NC = 4;
    localparam int AW = 12;

    typedef struct packed {
        logic [1:0]  op;    // 0 set line, 1 clear line, 2 write mask, 3 read register
        logic [7:0]  arg;   // line, cpu or register number
        logic [63:0] data;  // mask value or expected read value
        logic [3:0]  irq;   // expected cpu_irq afterwards
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd2, 8'd0,  64'h5,                  4'b0000},
        '{2'd0, 8'd2,  64'h0,                  4'b0001},
        '{2'd3, 8'd4,  64'h4,                  4'b0001},
        '{2'd2, 8'd1,  64'h8000_0000_0000_0000, 4'b0001},
        '{2'd0, 8'd63, 64'h0,                  4'b0011},
        '{2'd3, 8'd8,  64'h8000_0000_0000_0004, 4'b0011},
        '{2'd2, 8'd0,  64'h0,                  4'b0010},
        '{2'd3, 8'd4,  64'h0,                  4'b0010},
        '{2'd1, 8'd63, 64'h0,                  4'b0000},
        '{2'd1, 8'd63, 64'h0,                  4'b0000},
        '{2'd3, 8'd8,  64'h4,                  4'b0000},
        '{2'd2, 8'd3,  64'hFFFF_FFFF_FFFF_FFFF, 4'b1000},
        '{2'd3, 8'd3,  64'hFFFF_FFFF_FFFF_FFFF, 4'b1000},
        '{2'd3, 8'd7,  64'h4,                  4'b1000},
        '{2'd1, 8'd2,  64'h0,                  4'b0000}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NS-1:0]  src_assert = '0;
    logic [NS-1:0]  src_deassert = '0;
    logic           csr_valid = 1'b0;
    logic           csr_write = 1'b0;
    logic [AW-1:0]  csr_addr = '0;
    logic [1:0]     csr_size = 2'd3;
    logic [NS-1:0]  csr_wdata = '0;
    logic           csr_ack;
    logic           csr_err;
    logic [NS-1:0]  csr_rdata;
    logic [NC-1:0]  cpu_irq;
    logic [NC*6-1:0] cpu_low_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_router u_dut (
        .clk(clk), .rst(rst),
        .src_assert(src_assert), .src_deassert(src_deassert),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_size(csr_size), .csr_wdata(csr_wdata),
        .csr_ack(csr_ack), .csr_err(csr_err), .csr_rdata(csr_rdata),
        .cpu_irq(cpu_irq), .cpu_low_idx(cpu_low_idx)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr(input bit wr, input logic [AW-1:0] addr, input logic [1:0] sz,
                       input logic [63:0] wd, output logic [63:0] rd, output logic e);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = wr; csr_addr = addr; csr_size = sz; csr_wdata = wd;
        @(negedge clk);
        rd = csr_rdata; e = csr_err;
        check("R6 ack", {63'd0, csr_ack}, 64'd1);
        csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic strobe(input logic [63:0] a, input logic [63:0] d);
        @(negedge clk);
        src_assert = a; src_deassert = d;
        @(negedge clk);
        src_assert = '0; src_deassert = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic e;
        do_reset();

        // R1 reset state
        check("R1 irq", {60'd0, cpu_irq}, 64'd0);
        check("R1 idx", {40'd0, cpu_low_idx}, 64'd0);
        csr(1'b0, 12'd512, 2'd3, '0, rd, e);
        check("R1 raw", rd, 64'd0);
        csr(1'b0, 12'd64, 2'd3, '0, rd, e);
        check("R1 mask1", rd, 64'd0);

        // table walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NSTEP; i++) begin
            step_t s;
            s = STEPS[i];
            case (s.op)
                2'd0: strobe(64'd1 << s.arg, 64'd0);
                2'd1: strobe(64'd0, 64'd1 << s.arg);
                2'd2: csr(1'b1, AW'(s.arg) << 6, 2'd3, s.data, rd, e);
                default: begin
                    csr(1'b0, AW'(s.arg) << 6, 2'd3, '0, rd, e);
                    check("R6 read", rd, s.data);
                end
            endcase
            check("R2/R3/R4/R5/R10 irq", {60'd0, cpu_irq}, {60'd0, s.irq});
        end

        // R8 lowest pending index
        csr(1'b1, 12'd128, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, e);
        strobe((64'd1 << 40) | (64'd1 << 17), 64'd0);
        check("R8 idx low", {58'd0, cpu_low_idx[17:12]}, 64'd17);
        check("R8 irq2", {63'd0, cpu_irq[2]}, 64'd1);
        check("R8 idx idle cpu0", {58'd0, cpu_low_idx[5:0]}, 64'd0);
        strobe(64'd0, 64'd1 << 17);
        check("R8 idx next", {58'd0, cpu_low_idx[17:12]}, 64'd40);

        // R9 assert wins over deassert
        strobe(64'd1 << 5, 64'd1 << 5);
        csr(1'b0, 12'd512, 2'd3, '0, rd, e);
        check("R9 raw", rd, (64'd1 << 40) | (64'd1 << 5) | 64'd0);

        // R7 illegal accesses
        csr(1'b1, 12'd0, 2'd2, 64'hFF, rd, e);
        check("R7 size err", {63'd0, e}, 64'd1);
        csr(1'b1, 12'd8, 2'd3, 64'hFF, rd, e);
        check("R7 offset err", {63'd0, e}, 64'd1);
        csr(1'b0, 12'd0, 2'd3, '0, rd, e);
        check("R7 mask0 unchanged", rd, 64'd0);
        check("R7 legal no err", {63'd0, e}, 64'd0);
        csr(1'b1, 12'd256, 2'd3, 64'hFF, rd, e);
        check("R7 pend write err", {63'd0, e}, 64'd1);
        csr(1'b1, 12'd512, 2'd3, 64'h0, rd, e);
        check("R7 raw write err", {63'd0, e}, 64'd1);
        csr(1'b0, 12'd512, 2'd3, '0, rd, e);
        check("R7 raw unchanged", rd, (64'd1 << 40) | (64'd1 << 5));
        csr(1'b0, 12'd576, 2'd3, '0, rd, e);
        check("R7 unmapped err", {63'd0, e}, 64'd1);
        check("R7 unmapped data", rd, 64'd0);

        // R1 reset clears everything again
        do_reset();
        check("R1 irq after reset", {60'd0, cpu_irq}, 64'd0);
        csr(1'b0, 12'd192, 2'd3, '0, rd, e);
        check("R1 mask3 after reset", rd, 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule